// File: doc/BRIEF.md
# PHY management control register

This block holds the 16-bit control word of an Ethernet PHY's management register set, seen from a simple register bus. The bus decodes the address itself and presents a write strobe, write data and a continuous read-back word. The register also acts on the PHY. Setting its top bit starts a software reset that lasts a fixed number of clock cycles. During that reset every field returns to its default and all writes are refused. The register also combines a hardware auto-negotiation permit pin with the software enable bit. A write to the restart bit produces a single-cycle restart pulse. Level outputs carry loopback, isolate, duplex, collision test, the effective auto-negotiation enable and the effective link speed to the datapath.

Read-back shows the software view. The speed and auto-negotiation bits return what software last wrote, even when the pin or the negotiated result decides the actual behaviour. The serial management framing, the other registers and the negotiation engine sit outside this block.

Top module: `phy_mgmt_ctrl_reg`

## Requirements
- R1: A write with bit 15 set, accepted while no soft reset runs, starts a soft reset. On the next cycle every field is at its default, rd_data reads 16'hB000, and the other bits of that write are discarded, so no restart pulse is produced.
- R2: swrst_busy and read bit 15 stay high for exactly RST_CYCLES consecutive cycles, starting the cycle after the start write. After that, bit 15 reads 0.
- R3: While swrst_busy is high, every write is ignored, including the reset and restart bits, and rd_data does not change.
- R4: The read layout is: bit 14 loopback, bit 13 forced speed (1 = 100 Mb/s), bit 12 auto-negotiation software enable, bit 10 isolate, bit 8 full duplex, bit 7 collision test. Each of these reads back the value last written. Bit 11 and bits 6:0 always read 0.
- R5: While an_hw_allow is low, a write leaves bit 12 unchanged, and the other bits of that write still take effect.
- R6: an_enable_o is high only when an_hw_allow is high and bit 12 is 1. Bit 12 reads the software value whatever the pin level.
- R7: speed_100_o equals bit 13 while an_enable_o is low, and equals an_resolved_100 while it is high.
- R8: An accepted write with bit 9 set and bit 15 clear makes an_restart_o high for exactly the next cycle. Bit 9 reads 1 in that cycle and 0 afterwards.
- R9: After a clock edge with rst_n low, rd_data is 16'h3000 and both swrst_busy and an_restart_o are 0.
- R10: loopback_o, isolate_o, full_duplex_o and col_test_o follow bits 14, 10, 8 and 7 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Address-decoded write strobe |
| wr_data | input | 16 | Write data |
| an_hw_allow | input | 1 | Hardware auto-negotiation permit; low disables it |
| an_resolved_100 | input | 1 | Speed resolved by auto-negotiation, 1 = 100 Mb/s |
| rd_data | output | 16 | Read-back word |
| swrst_busy | output | 1 | Soft reset in progress |
| loopback_o | output | 1 | Loopback mode |
| isolate_o | output | 1 | Isolate PHY from the MAC interface |
| full_duplex_o | output | 1 | Forced full duplex |
| col_test_o | output | 1 | Collision test enable |
| an_enable_o | output | 1 | Effective auto-negotiation enable |
| an_restart_o | output | 1 | One-cycle auto-negotiation restart pulse |
| speed_100_o | output | 1 | Effective speed, 1 = 100 Mb/s |

## Verification
The hardest situation to reach is a write that arrives inside the soft-reset window and tries to change fields or pulse a restart. It has to be refused, and the window must still last exactly RST_CYCLES cycles. The stimulus first loads a non-default register and then issues the reset. While the reset runs, it drives a write carrying loopback and restart. It counts busy cycles at the ports, watches for any restart pulse, and confirms that the read word stays at the reset value until the window closes.

// File: rtl/phy_ctl_pkg.sv
// Package: bit positions and field types shared by the control register.
// Assumes a 16-bit register word; positions are those software decodes.
package phy_ctl_pkg;
    localparam int REG_W    = 16;
    localparam int B_SWRST  = 15;
    localparam int B_LOOP   = 14;
    localparam int B_SPEED  = 13;
    localparam int B_AN_EN  = 12;
    localparam int B_ISO    = 10;
    localparam int B_RESTRT = 9;
    localparam int B_DUPLEX = 8;
    localparam int B_COLTST = 7;

    typedef struct packed {
        logic loopback;
        logic speed_100;
        logic an_sw_en;
        logic isolate;
        logic full_duplex;
        logic col_test;
    } ctl_fields_t;

    localparam ctl_fields_t FIELDS_DEFAULT = '{
        loopback: 1'b0, speed_100: 1'b1, an_sw_en: 1'b1,
        isolate: 1'b0, full_duplex: 1'b0, col_test: 1'b0
    };
endpackage

// File: rtl/phy_swrst_timer.sv
// Module: soft-reset timer. A start pulse raises busy for exactly
// RST_CYCLES cycles. Assumes start is only asserted while busy is low.
module phy_swrst_timer #(
    parameter int RST_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the down-counter on start, release busy when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_LOAD;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/phy_ctl_fields.sv
// Module: storage for the writable control fields plus the restart pulse.
// Assumes the caller has already removed writes refused by the busy lock.
module phy_ctl_fields
    import phy_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swrst_start,
    input  logic               fld_wr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               an_hw_allow,
    output ctl_fields_t        fields,
    output logic               restart_q
);
    // Update fields from accepted writes; soft reset restores defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields    <= FIELDS_DEFAULT;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (swrst_start) begin
                fields <= FIELDS_DEFAULT;
            end else if (fld_wr) begin
                fields.loopback    <= wr_data[B_LOOP];
                fields.speed_100   <= wr_data[B_SPEED];
                fields.isolate     <= wr_data[B_ISO];
                fields.full_duplex <= wr_data[B_DUPLEX];
                fields.col_test    <= wr_data[B_COLTST];
                if (an_hw_allow) begin
                    fields.an_sw_en <= wr_data[B_AN_EN];
                end
                restart_q <= wr_data[B_RESTRT];
            end
        end
    end
endmodule

// File: rtl/phy_ctl_resolve.sv
// Module: combines the hardware permit with the software enable and picks
// the effective speed. Purely combinational.
module phy_ctl_resolve (
    input  logic an_hw_allow,
    input  logic an_sw_en,
    input  logic forced_100,
    input  logic an_resolved_100,
    output logic an_enable,
    output logic speed_100
);
    // Negotiated speed applies only while negotiation is effectively on.
    always_comb begin
        an_enable = an_hw_allow & an_sw_en;
        speed_100 = an_enable ? an_resolved_100 : forced_100;
    end
endmodule

// File: rtl/phy_mgmt_ctrl_reg.sv
// Module: PHY management control register top. It gates bus writes with
// the soft-reset lock, assembles read-back and drives datapath controls.
// Assumes wr_en is already qualified by the register address.
module phy_mgmt_ctrl_reg
    import phy_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        an_hw_allow,
    input  logic        an_resolved_100,
    output logic [15:0] rd_data,
    output logic        swrst_busy,
    output logic        loopback_o,
    output logic        isolate_o,
    output logic        full_duplex_o,
    output logic        col_test_o,
    output logic        an_enable_o,
    output logic        an_restart_o,
    output logic        speed_100_o
);
    ctl_fields_t fields;
    logic        wr_accept;
    logic        swrst_start;
    logic        fld_wr;
    logic        restart_q;
    logic        unused_bits;

    // Refuse all writes during soft reset; bit 15 takes precedence.
    always_comb begin
        wr_accept   = wr_en & ~swrst_busy;
        swrst_start = wr_accept & wr_data[B_SWRST];
        fld_wr      = wr_accept & ~wr_data[B_SWRST];
        unused_bits = ^{wr_data[11], wr_data[6:0]};
    end

    phy_swrst_timer #(.RST_CYCLES(RST_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (swrst_start),
        .busy  (swrst_busy)
    );

    phy_ctl_fields fields_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .swrst_start (swrst_start),
        .fld_wr      (fld_wr),
        .wr_data     (wr_data),
        .an_hw_allow (an_hw_allow),
        .fields      (fields),
        .restart_q   (restart_q)
    );

    phy_ctl_resolve resolve_i (
        .an_hw_allow     (an_hw_allow),
        .an_sw_en        (fields.an_sw_en),
        .forced_100      (fields.speed_100),
        .an_resolved_100 (an_resolved_100),
        .an_enable       (an_enable_o),
        .speed_100       (speed_100_o)
    );

    // Assemble the read word from software state; reserved bits read 0.
    always_comb begin
        rd_data           = '0;
        rd_data[B_SWRST]  = swrst_busy;
        rd_data[B_LOOP]   = fields.loopback;
        rd_data[B_SPEED]  = fields.speed_100;
        rd_data[B_AN_EN]  = fields.an_sw_en;
        rd_data[B_ISO]    = fields.isolate;
        rd_data[B_RESTRT] = restart_q;
        rd_data[B_DUPLEX] = fields.full_duplex;
        rd_data[B_COLTST] = fields.col_test;
    end

    // Drive the datapath control levels.
    always_comb begin
        loopback_o    = fields.loopback;
        isolate_o     = fields.isolate;
        full_duplex_o = fields.full_duplex;
        col_test_o    = fields.col_test;
        an_restart_o  = restart_q;
    end
endmodule

// File: rtl/phy_mgmt_ctrl_chk.sv
// Module: assertion checker for the control register, bound to the top.
// Measures the busy window with a counter instead of a long $past.
module phy_mgmt_ctrl_chk #(
    parameter int RST_CYCLES = 25
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        an_hw_allow,
    input logic [15:0] rd_data,
    input logic        swrst_busy,
    input logic        an_enable_o,
    input logic        an_restart_o,
    input logic        speed_100_o
);
    localparam int RUN_W = $clog2(RST_CYCLES + 2);
    logic [RUN_W-1:0] run_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_len <= '0;
        else if (swrst_busy) run_len <= run_len + 1'b1;
        else                 run_len <= '0;
    end

    p_swrst_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !swrst_busy && wr_data[15])
        |=> (swrst_busy && rd_data == 16'hB000 && !an_restart_o));

    p_busy_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swrst_busy) |-> (run_len == RUN_W'(RST_CYCLES)));

    p_frozen_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (swrst_busy && $past(swrst_busy)) |-> $stable(rd_data));

    p_pin_blocks_an_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !an_hw_allow && !wr_data[15]) |=> $stable(rd_data[12]));

    p_forced_speed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !an_enable_o |-> (speed_100_o == rd_data[13]));

    p_restart_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !swrst_busy && !wr_data[15] && wr_data[9])
        |=> (an_restart_o && rd_data[9]));

    p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || swrst_busy) |=> !an_restart_o);
endmodule

bind phy_mgmt_ctrl_reg phy_mgmt_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .an_hw_allow  (an_hw_allow),
    .rd_data      (rd_data),
    .swrst_busy   (swrst_busy),
    .an_enable_o  (an_enable_o),
    .an_restart_o (an_restart_o),
    .speed_100_o  (speed_100_o)
);

// File: tb/phy_mgmt_ctrl_reg_tb_top.sv
// Bench: vector table walked by one loop, then directed soft-reset,
// lockout and pin-reset tests. Drives and samples on falling edges.
module phy_mgmt_ctrl_reg_tb_top;
    localparam int RST_CYCLES = 25;

    typedef struct packed {
        logic        wr;
        logic [15:0] data;
        logic        pin;
        logic        res;
        logic [15:0] exp_rd;
        logic        exp_spd;
        logic        exp_an;
        logic        exp_rs;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 1'b1, 1'b0, 16'h3000, 1'b0, 1'b1, 1'b0},
        '{1'b0, 16'h0000, 1'b1, 1'b1, 16'h3000, 1'b1, 1'b1, 1'b0},
        '{1'b1, 16'h4100, 1'b1, 1'b1, 16'h4100, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'h2580, 1'b1, 1'b0, 16'h2580, 1'b1, 1'b0, 1'b0},
        '{1'b1, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'h1100, 1'b0, 1'b1, 16'h0100, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'h0000, 1'b1, 1'b1, 16'h0100, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'h1000, 1'b1, 1'b1, 16'h1000, 1'b1, 1'b1, 1'b0},
        '{1'b0, 16'h0000, 1'b0, 1'b1, 16'h1000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'h0847, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'h3000, 1'b1, 1'b0, 16'h3000, 1'b0, 1'b1, 1'b0},
        '{1'b1, 16'h3200, 1'b1, 1'b1, 16'h3200, 1'b1, 1'b1, 1'b1},
        '{1'b0, 16'h0000, 1'b1, 1'b1, 16'h3000, 1'b1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        an_hw_allow = 1'b1;
    logic        an_resolved_100 = 1'b0;
    logic [15:0] rd_data;
    logic        swrst_busy, loopback_o, isolate_o, full_duplex_o, col_test_o;
    logic        an_enable_o, an_restart_o, speed_100_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    phy_mgmt_ctrl_reg #(.RST_CYCLES(RST_CYCLES)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .an_hw_allow     (an_hw_allow),
        .an_resolved_100 (an_resolved_100),
        .rd_data         (rd_data),
        .swrst_busy      (swrst_busy),
        .loopback_o      (loopback_o),
        .isolate_o       (isolate_o),
        .full_duplex_o   (full_duplex_o),
        .col_test_o      (col_test_o),
        .an_enable_o     (an_enable_o),
        .an_restart_o    (an_restart_o),
        .speed_100_o     (speed_100_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int busy_cnt;
        bit saw_restart;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table: R4 R5 R6 R7 R8 under assorted pin/speed patterns.
        for (int i = 0; i < NV; i++) begin
            wr_en = VECS[i].wr;
            wr_data = VECS[i].data;
            an_hw_allow = VECS[i].pin;
            an_resolved_100 = VECS[i].res;
            @(negedge clk);
            check($sformatf("R4 R5 rd_data vec %0d", i), rd_data, VECS[i].exp_rd);
            check($sformatf("R6 an_enable_o vec %0d", i), 16'(an_enable_o), 16'(VECS[i].exp_an));
            check($sformatf("R7 speed_100_o vec %0d", i), 16'(speed_100_o), 16'(VECS[i].exp_spd));
            check($sformatf("R8 an_restart_o vec %0d", i), 16'(an_restart_o), 16'(VECS[i].exp_rs));
            wr_en = 1'b0;
            wr_data = '0;
        end

        // R10: datapath levels follow the stored bits.
        an_hw_allow = 1'b1;
        write_word(16'h4580);
        check("R10 outputs", {12'h0, loopback_o, isolate_o, full_duplex_o, col_test_o}, 16'h000F);

        // R1: soft reset with restart bit also set; restart discarded.
        write_word(16'h8200);
        check("R1 rd_data after start", rd_data, 16'hB000);
        check("R1 no restart", 16'(an_restart_o), 16'h0);
        busy_cnt = swrst_busy ? 1 : 0;
        saw_restart = 1'b0;

        // R3: write during busy; R2: count the busy window.
        wr_en = 1'b1;
        wr_data = 16'h4200;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        if (swrst_busy) busy_cnt++;
        if (an_restart_o) saw_restart = 1'b1;
        check("R3 rd frozen during busy", rd_data, 16'hB000);
        for (int k = 0; k < 4 * RST_CYCLES && swrst_busy; k++) begin
            @(negedge clk);
            if (swrst_busy) busy_cnt++;
            if (an_restart_o) saw_restart = 1'b1;
        end
        check("R2 busy cycles", 16'(busy_cnt), 16'(RST_CYCLES));
        check("R2 bit15 cleared", rd_data, 16'h3000);
        check("R3 no restart during busy", 16'(saw_restart), 16'h0);

        // R3 counterpart: writes accepted again once busy has ended.
        write_word(16'h4000);
        check("R3 write accepted after busy", rd_data, 16'h4000);

        // R9: pin reset restores defaults mid-state.
        write_word(16'h0580);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 rd_data", rd_data, 16'h3000);
        check("R9 busy and restart", {14'h0, swrst_busy, an_restart_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule